// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block collects interrupt events for a storage-card host controller and folds them, together with a request from a sibling controller, into one interrupt line. It has two levels.

At the local level, one-cycle event pulses set sticky status bits. Software clears a bit by writing a 1 to it. A local enable mask selects which status bits count as pending. At the global level, each of the two controllers owns one sticky bit. A status-enable mask decides whether a request is recorded in that bit. A separate signal-enable mask decides whether a recorded bit drives the shared output line.

Software reaches every register through a synchronous word-addressed port. Reads return data combinationally in the cycle of the request.

Top module: `irq_hub`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. This holds for local status, local enable, global status, global status-enable and global signal-enable.
- R2: A pulse on `evt[i]` sets local status bit i at the next clock edge. Only bits 0–3 and 8–11 exist: card detect is bit 0, status change bit 1, memory mode bit 2, I/O mode bit 3, IDE mode bit 8, PIO error bit 9, buffer ready bit 10 and transfer done bit 11. All other bits read zero.
- R3: Writing word address 0x001 clears each local status bit whose data bit is 1. Data bits that are 0 leave the status unchanged.
- R4: If an event and a clearing write hit the same local bit in one cycle, the bit stays set.
- R5: Local enable sits at word address 0x002. It is read/write, and only the implemented bit positions of R2 hold a value.
- R6: Global bit 0 (this controller) becomes set one cycle after `(local status AND local enable) != 0` while global status-enable bit 0 is 1. While status-enable bit 0 is 0, global bit 0 stays clear.
- R7: Global bit 1 (sibling) becomes set one cycle after `sib_req` is high while global status-enable bit 1 is 1. While status-enable bit 1 is 0, global bit 1 stays clear.
- R8: Writing 1s to word address 0x200 clears those global bits. If the set condition of a bit holds in the same cycle, that bit stays set.
- R9: `irq` is a register. It is loaded each cycle with the OR of (global status AND global signal-enable), so it follows one cycle behind.
- R10: Reads of undefined word addresses return zero. Writes to them change no register.
- R11: The word address map is as follows. Global status-enable is at 0x201 and global signal-enable at 0x202; each is 2 bits wide, bit 0 for this controller and bit 1 for the sibling. Local status is at 0x001 (byte 0x004), local enable at 0x002 and global status at 0x200 (byte 0x800).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | 12 | Local event pulses, one per status bit |
| sib_req | input | 1 | Interrupt request level from the sibling controller |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq | output | 1 | Shared interrupt line |

## Verification
The local stage is driven three ways: with all twelve event lines at once, which separates implemented positions from absent ones; with clearing writes that mix 1s and 0s; and with an event that collides with a clear. The global stage is fed a local pending condition and a sibling request, each first with its status-enable off and then on. This shows whether recording is gated independently per controller. The signal-enable is set to one bit while the other bit is pending, which shows that the recording mask and the signalling mask act separately. A global clear is issued both while the local condition still holds and after it has gone, which distinguishes the set-wins rule from a plain clear.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 10;
    localparam int LOC_W  = 12;
    localparam int GLB_W  = 2;

    // implemented local source positions
    localparam int SRC_CARD   = 0;
    localparam int SRC_CHG    = 1;
    localparam int SRC_MEM    = 2;
    localparam int SRC_IO     = 3;
    localparam int SRC_IDE    = 8;
    localparam int SRC_PIOERR = 9;
    localparam int SRC_BUFRDY = 10;
    localparam int SRC_DONE   = 11;

    localparam logic [LOC_W-1:0] LOC_IMPL =
        LOC_W'((1 << SRC_CARD) | (1 << SRC_CHG) | (1 << SRC_MEM) | (1 << SRC_IO) |
               (1 << SRC_IDE) | (1 << SRC_PIOERR) | (1 << SRC_BUFRDY) | (1 << SRC_DONE));

    // word addresses (byte offset / 4)
    localparam logic [ADDR_W-1:0] A_LSTAT = 10'h001;
    localparam logic [ADDR_W-1:0] A_LEN   = 10'h002;
    localparam logic [ADDR_W-1:0] A_GSTAT = 10'h200;
    localparam logic [ADDR_W-1:0] A_GSEN  = 10'h201;
    localparam logic [ADDR_W-1:0] A_GSIG  = 10'h202;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LSTAT,
        SEL_LEN,
        SEL_GSTAT,
        SEL_GSEN,
        SEL_GSIG
    } reg_sel_e;

    typedef struct packed {
        logic lstat;
        logic len;
        logic gstat;
        logic gsen;
        logic gsig;
    } wr_strobe_t;

    function automatic reg_sel_e addr_decode(input logic [ADDR_W-1:0] a);
        case (a)
            A_LSTAT: return SEL_LSTAT;
            A_LEN:   return SEL_LEN;
            A_GSTAT: return SEL_GSTAT;
            A_GSEN:  return SEL_GSEN;
            A_GSIG:  return SEL_GSIG;
            default: return SEL_NONE;
        endcase
    endfunction

    // sticky write-one-to-clear bit: a set in the same cycle beats the clear
    function automatic logic sticky_bit(input logic cur, input logic set, input logic clr);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/irqh_decode.sv
module irqh_decode
    import irqh_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    output reg_sel_e      rd_sel,
    output wr_strobe_t    wr
);
    reg_sel_e sel;

    always_comb begin
        sel    = addr_decode(addr);
        rd_sel = (valid && !write) ? sel : SEL_NONE;
        wr       = '0;
        wr.lstat = valid && write && (sel == SEL_LSTAT);
        wr.len   = valid && write && (sel == SEL_LEN);
        wr.gstat = valid && write && (sel == SEL_GSTAT);
        wr.gsen  = valid && write && (sel == SEL_GSEN);
        wr.gsig  = valid && write && (sel == SEL_GSIG);
    end
endmodule

// File: rtl/irqh_local.sv
module irqh_local
    import irqh_pkg::*;
#(
    parameter int               LW   = LOC_W,
    parameter logic [LW-1:0]    IMPL = LOC_IMPL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] evt,
    input  logic          wr_stat,
    input  logic          wr_en,
    input  logic [LW-1:0] wdata,
    output logic [LW-1:0] stat,
    output logic [LW-1:0] en,
    output logic          pending
);
    for (genvar i = 0; i < LW; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic st_q, en_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q <= 1'b0;
                    en_q <= 1'b0;
                end else begin
                    st_q <= sticky_bit(st_q, evt[i], wr_stat & wdata[i]);
                    if (wr_en) en_q <= wdata[i];
                end
            end
            assign stat[i] = st_q;
            assign en[i]   = en_q;
        end else begin : g_absent
            logic unused_evt;
            assign unused_evt = evt[i] ^ wdata[i] ^ wr_stat ^ wr_en;
            assign stat[i] = 1'b0;
            assign en[i]   = 1'b0;
        end
    end

    assign pending = |(stat & en);
endmodule

// File: rtl/irqh_global.sv
module irqh_global
    import irqh_pkg::*;
#(
    parameter int GW = GLB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [GW-1:0] req,
    input  logic          wr_stat,
    input  logic          wr_sen,
    input  logic          wr_sig,
    input  logic [GW-1:0] wdata,
    output logic [GW-1:0] gstat,
    output logic [GW-1:0] gsen,
    output logic [GW-1:0] gsig,
    output logic          irq
);
    for (genvar i = 0; i < GW; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                gstat[i] <= 1'b0;
                gsen[i]  <= 1'b0;
                gsig[i]  <= 1'b0;
            end else begin
                gstat[i] <= sticky_bit(gstat[i], req[i] & gsen[i], wr_stat & wdata[i]);
                if (wr_sen) gsen[i] <= wdata[i];
                if (wr_sig) gsig[i] <= wdata[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(gstat & gsig);
    end
endmodule

// File: rtl/irqh_rdmux.sv
module irqh_rdmux
    import irqh_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LOC_W,
    parameter int GW = GLB_W
) (
    input  reg_sel_e      sel,
    input  logic [LW-1:0] lstat,
    input  logic [LW-1:0] len,
    input  logic [GW-1:0] gstat,
    input  logic [GW-1:0] gsen,
    input  logic [GW-1:0] gsig,
    output logic [DW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_LSTAT: rdata = DW'(lstat);
            SEL_LEN:   rdata = DW'(len);
            SEL_GSTAT: rdata = DW'(gstat);
            SEL_GSEN:  rdata = DW'(gsen);
            SEL_GSIG:  rdata = DW'(gsig);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irqh_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int LW = LOC_W,
    parameter int GW = GLB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] evt,
    input  logic [GW-2:0] sib_req,
    input  logic          reg_valid,
    input  logic          reg_write,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    reg_sel_e      rd_sel;
    wr_strobe_t    wr;
    logic [LW-1:0] lstat_w, len_w;
    logic          loc_pend;
    logic [GW-1:0] gstat_w, gsen_w, gsig_w;
    logic          unused_wdata;

    assign unused_wdata = ^reg_wdata[DW-1:LW];

    irqh_decode #(.AW(AW)) u_dec (
        .valid (reg_valid),
        .write (reg_write),
        .addr  (reg_addr),
        .rd_sel(rd_sel),
        .wr    (wr)
    );

    irqh_local #(.LW(LW), .IMPL(LOC_IMPL)) u_loc (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .wr_stat(wr.lstat),
        .wr_en  (wr.len),
        .wdata  (reg_wdata[LW-1:0]),
        .stat   (lstat_w),
        .en     (len_w),
        .pending(loc_pend)
    );

    // bit 0: this controller, upper bits: siblings
    irqh_global #(.GW(GW)) u_glb (
        .clk    (clk),
        .rst    (rst),
        .req    ({sib_req, loc_pend}),
        .wr_stat(wr.gstat),
        .wr_sen (wr.gsen),
        .wr_sig (wr.gsig),
        .wdata  (reg_wdata[GW-1:0]),
        .gstat  (gstat_w),
        .gsen   (gsen_w),
        .gsig   (gsig_w),
        .irq    (irq)
    );

    irqh_rdmux #(.DW(DW), .LW(LW), .GW(GW)) u_rd (
        .sel  (rd_sel),
        .lstat(lstat_w),
        .len  (len_w),
        .gstat(gstat_w),
        .gsen (gsen_w),
        .gsig (gsig_w),
        .rdata(reg_rdata)
    );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
    import irqh_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int LW = LOC_W,
    parameter int GW = GLB_W
) (
    input logic          clk,
    input logic          rst,
    input logic [LW-1:0] evt,
    input logic [GW-2:0] sib_req,
    input logic          reg_valid,
    input logic          reg_write,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          irq,
    input logic [LW-1:0] lstat,
    input logic [LW-1:0] len,
    input logic [GW-1:0] gstat,
    input logic [GW-1:0] gsen,
    input logic [GW-1:0] gsig
);
    logic wr_l, wr_undef;
    assign wr_l     = reg_valid && reg_write && (reg_addr == A_LSTAT);
    assign wr_undef = reg_valid && reg_write && (addr_decode(reg_addr) == SEL_NONE);

    // R1: reset clears state and line
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (lstat == '0 && gstat == '0 && !irq));

    // R2 and R4: an implemented event is always captured, even under a clear
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (|(evt & LOC_IMPL)) |=> ((lstat & $past(evt & LOC_IMPL)) == $past(evt & LOC_IMPL)));

    // R3: cleared bits without a colliding event are zero afterwards
    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        wr_l |=> ((lstat & $past(reg_wdata[LW-1:0]) & ~$past(evt)) == '0));

    // R6: pending local source recorded when status-enable allows
    assert_gcf_set_R6: assert property (@(posedge clk) disable iff (rst)
        ((|(lstat & len)) && gsen[0]) |=> gstat[0]);

    assert_gcf_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (!gstat[0] && !gsen[0]) |=> !gstat[0]);

    // R7: sibling request recorded when status-enable allows
    assert_gsib_R7: assert property (@(posedge clk) disable iff (rst)
        (sib_req[0] && gsen[1]) |=> gstat[1]);

    // R9: the line only rises when a signalled bit was pending
    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|(gstat & gsig)));

    // R10: writes to undefined addresses leave the masks alone
    assert_undef_R10: assert property (@(posedge clk) disable iff (rst)
        wr_undef |=> ($stable(len) && $stable(gsen) && $stable(gsig)));
endmodule

bind irq_hub irq_hub_chk #(.DW(DW), .AW(AW), .LW(LW), .GW(GW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .sib_req  (sib_req),
    .reg_valid(reg_valid),
    .reg_write(reg_write),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .irq      (irq),
    .lstat    (lstat_w),
    .len      (len_w),
    .gstat    (gstat_w),
    .gsen     (gsen_w),
    .gsig     (gsig_w)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
    localparam int DW = 32;
    localparam int AW = 10;
    localparam int LW = 12;

    typedef enum logic [1:0] {K_IDLE, K_WR, K_RD, K_IRQ} kind_e;

    typedef struct packed {
        kind_e         kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [LW-1:0] evt;
        logic          sib;
        logic [DW-1:0] exp;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 49;
    localparam vec_t VECS [NV] = '{
        '{K_IRQ,  10'h000, 32'h0,        12'h000, 1'b0, 32'h0,   4'd1},  // R1
        '{K_RD,   10'h001, 32'h0,        12'h000, 1'b0, 32'h0,   4'd1},  // R1
        '{K_RD,   10'h200, 32'h0,        12'h000, 1'b0, 32'h0,   4'd1},  // R1
        '{K_RD,   10'h201, 32'h0,        12'h000, 1'b0, 32'h0,   4'd1},  // R1
        '{K_IDLE, 10'h000, 32'h0,        12'hFFF, 1'b0, 32'h0,   4'd2},  // R2
        '{K_RD,   10'h001, 32'h0,        12'h000, 1'b0, 32'hF0F, 4'd2},  // R2
        '{K_WR,   10'h001, 32'h3,        12'h000, 1'b0, 32'h0,   4'd3},  // R3
        '{K_RD,   10'h001, 32'h0,        12'h000, 1'b0, 32'hF0C, 4'd3},  // R3
        '{K_WR,   10'h001, 32'h0,        12'h000, 1'b0, 32'h0,   4'd3},  // R3
        '{K_RD,   10'h001, 32'h0,        12'h000, 1'b0, 32'hF0C, 4'd3},  // R3
        '{K_WR,   10'h001, 32'h800,      12'h800, 1'b0, 32'h0,   4'd4},  // R4
        '{K_RD,   10'h001, 32'h0,        12'h000, 1'b0, 32'hF0C, 4'd4},  // R4
        '{K_WR,   10'h002, 32'hFFFFFFFF, 12'h000, 1'b0, 32'h0,   4'd5},  // R5
        '{K_RD,   10'h002, 32'h0,        12'h000, 1'b0, 32'hF0F, 4'd5},  // R5
        '{K_RD,   10'h200, 32'h0,        12'h000, 1'b0, 32'h0,   4'd6},  // R6 gated
        '{K_WR,   10'h201, 32'h1,        12'h000, 1'b0, 32'h0,   4'd6},  // R6
        '{K_IDLE, 10'h000, 32'h0,        12'h000, 1'b0, 32'h0,   4'd6},  // R6
        '{K_RD,   10'h200, 32'h0,        12'h000, 1'b0, 32'h1,   4'd6},  // R6
        '{K_IRQ,  10'h000, 32'h0,        12'h000, 1'b0, 32'h0,   4'd9},  // R9
        '{K_WR,   10'h202, 32'h1,        12'h000, 1'b0, 32'h0,   4'd9},  // R9
        '{K_IDLE, 10'h000, 32'h0,        12'h000, 1'b0, 32'h0,   4'd9},  // R9
        '{K_IRQ,  10'h000, 32'h0,        12'h000, 1'b0, 32'h1,   4'd9},  // R9
        '{K_WR,   10'h001, 32'hFFF,      12'h000, 1'b0, 32'h0,   4'd3},  // R3
        '{K_WR,   10'h200, 32'h1,        12'h000, 1'b0, 32'h0,   4'd8},  // R8
        '{K_RD,   10'h200, 32'h0,        12'h000, 1'b0, 32'h0,   4'd8},  // R8
        '{K_IRQ,  10'h000, 32'h0,        12'h000, 1'b0, 32'h0,   4'd9},  // R9
        '{K_IDLE, 10'h000, 32'h0,        12'h001, 1'b0, 32'h0,   4'd8},  // R8
        '{K_WR,   10'h200, 32'h1,        12'h000, 1'b0, 32'h0,   4'd8},  // R8 set wins
        '{K_RD,   10'h200, 32'h0,        12'h000, 1'b0, 32'h1,   4'd8},  // R8
        '{K_WR,   10'h001, 32'h1,        12'h000, 1'b0, 32'h0,   4'd3},  // R3
        '{K_WR,   10'h200, 32'h1,        12'h000, 1'b0, 32'h0,   4'd8},  // R8
        '{K_RD,   10'h200, 32'h0,        12'h000, 1'b0, 32'h0,   4'd8},  // R8
        '{K_IDLE, 10'h000, 32'h0,        12'h000, 1'b1, 32'h0,   4'd7},  // R7 gated
        '{K_RD,   10'h200, 32'h0,        12'h000, 1'b0, 32'h0,   4'd7},  // R7
        '{K_WR,   10'h201, 32'h3,        12'h000, 1'b0, 32'h0,   4'd7},  // R7
        '{K_IDLE, 10'h000, 32'h0,        12'h000, 1'b1, 32'h0,   4'd7},  // R7
        '{K_RD,   10'h200, 32'h0,        12'h000, 1'b0, 32'h2,   4'd7},  // R7
        '{K_IRQ,  10'h000, 32'h0,        12'h000, 1'b0, 32'h0,   4'd9},  // R9 not signalled
        '{K_WR,   10'h202, 32'h2,        12'h000, 1'b0, 32'h0,   4'd9},  // R9
        '{K_IDLE, 10'h000, 32'h0,        12'h000, 1'b0, 32'h0,   4'd9},  // R9
        '{K_IRQ,  10'h000, 32'h0,        12'h000, 1'b0, 32'h1,   4'd9},  // R9
        '{K_WR,   10'h003, 32'hFFFF,     12'h000, 1'b0, 32'h0,   4'd10}, // R10
        '{K_RD,   10'h003, 32'h0,        12'h000, 1'b0, 32'h0,   4'd10}, // R10
        '{K_RD,   10'h1FF, 32'h0,        12'h000, 1'b0, 32'h0,   4'd10}, // R10
        '{K_RD,   10'h002, 32'h0,        12'h000, 1'b0, 32'hF0F, 4'd10}, // R10
        '{K_WR,   10'h201, 32'hFFFFFFFF, 12'h000, 1'b0, 32'h0,   4'd11}, // R11
        '{K_RD,   10'h201, 32'h0,        12'h000, 1'b0, 32'h3,   4'd11}, // R11
        '{K_RD,   10'h202, 32'h0,        12'h000, 1'b0, 32'h2,   4'd11}, // R11
        '{K_RD,   10'h001, 32'h0,        12'h000, 1'b0, 32'h0,   4'd11}  // R11
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LW-1:0] evt = '0;
    logic [0:0]    sib_req = '0;
    logic          reg_valid = 1'b0;
    logic          reg_write = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    irq_hub u_irq_hub (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .sib_req  (sib_req),
        .reg_valid(reg_valid),
        .reg_write(reg_write),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq      (irq)
    );

    task automatic check(input int req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        evt       = v.evt;
        sib_req   = v.sib;
        reg_valid = (v.kind == K_WR) || (v.kind == K_RD);
        reg_write = (v.kind == K_WR);
        reg_addr  = v.addr;
        reg_wdata = v.data;
        #1;
        if (v.kind == K_RD)  check(int'(v.req), reg_rdata, v.exp);
        if (v.kind == K_IRQ) check(int'(v.req), {31'b0, irq}, v.exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R2: events on absent positions leave status zero
        run_vec('{K_IDLE, 10'h000, 32'h0, 12'h0F0, 1'b0, 32'h0, 4'd2});
        run_vec('{K_RD,   10'h001, 32'h0, 12'h000, 1'b0, 32'h0, 4'd2});

        // R1: reset in mid-run with state pending
        run_vec('{K_IDLE, 10'h000, 32'h0, 12'h800, 1'b0, 32'h0, 4'd1});
        @(negedge clk);
        evt = '0; reg_valid = 1'b0; reg_write = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_vec('{K_RD,  10'h001, 32'h0, 12'h000, 1'b0, 32'h0, 4'd1});
        run_vec('{K_RD,  10'h002, 32'h0, 12'h000, 1'b0, 32'h0, 4'd1});
        run_vec('{K_RD,  10'h202, 32'h0, 12'h000, 1'b0, 32'h0, 4'd1});
        run_vec('{K_IRQ, 10'h000, 32'h0, 12'h000, 1'b0, 32'h0, 4'd1});
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule